// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight edge-triggered interrupt request lines and presents at most one interrupt at a time to a processor. Software programs it through a byte-wide register bus that has a chip select, a one-bit port address (0 = command port, 1 = data port) and write and read strobes. Setup is a short chain of initialization writes. The first word goes to the command port and the remaining words go to the data port. The number of words in the chain depends on options chosen in the first word. Once the chain is complete, data-port writes change the mask.

A rising edge on an input records a pending request. The interrupt output rises when the best unmasked pending request outranks everything already in service. Input 0 has the highest priority. When the processor pulses the acknowledge input, the winner moves from pending to in-service, and an 8-bit vector is returned. The vector is the programmed base in bits 7:3 and the input number in bits 2:0. Software ends a handler with an end-of-interrupt command. That command either retires the highest in-service level or names one level explicitly.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `int_out` is 0, a data-port read returns mask 0xFF and a command-port read returns in-service 0x00. A read returns on `rdata` the cycle after the read strobe: the data port gives the mask and the command port gives the in-service register.
- R2: Data-port writes made before any initialization word has been received are ignored, so the mask stays 0xFF.
- R3: A command write with bit 4 set starts initialization. In that word, bit 1 = 1 means single operation, bit 0 = 1 means a fourth word follows, and bit 3 is accepted but edge triggering is always used. The next data write sets the vector base from bits 7:3. With bit 1 = 1 and bit 0 = 0, the write after that already loads the mask.
- R4: With bit 1 = 0, one data write (the cascade word) follows the base. With bit 0 = 1, one further data write (the mode word) follows. Neither of these words changes the mask, and only the data write after them loads the mask.
- R5: A rising input edge sets a request bit that stays set after the input falls. A mask bit of 1 keeps that request from raising `int_out`, and clearing the mask bit later raises `int_out`. An input held high gives no further request.
- R6: Input 0 has the highest priority and input 7 the lowest. The vector, valid from the cycle after the acknowledge pulse, is {base[7:3], winning input number}.
- R7: An acknowledge while `int_out` is 1 sets the winner's in-service bit and clears its request bit.
- R8: `int_out` is 1 only when the highest unmasked pending request has a smaller input number than every in-service bit.
- R9: A command write of 0x20 clears the lowest-numbered set in-service bit.
- R10: A command write of 0x60+n (n = 0..7) clears only in-service bit n.
- R11: An acknowledge while `int_out` is 0 returns {base[7:3], 3'b111} and changes neither the request nor the in-service state.
- R12: An initialization word clears all request and in-service bits and sets the mask to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for register access |
| addr | input | 1 | Port select: 0 command, 1 data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_in | input | 8 | Edge-triggered request inputs |
| inta | input | 1 | One-cycle acknowledge pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector of the last acknowledge |

## Verification
The hardest situation to reach from the ports is an acknowledge that arrives while a request is pending but is blocked by a higher in-service level. That is the spurious case, and it must leave both pending and in-service state untouched. The stimulus first puts input 2 in service while input 6 is still pending, then acknowledges again. After that it retires level 2 and confirms that input 6 still wins and returns its own vector. Nested ordering is driven in the same way. A low-priority request is left waiting behind an in-service level, a higher one interrupts on top of it, and the two kinds of end-of-interrupt are then used to unwind the levels one at a time.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    typedef enum logic [2:0] {
        SEQ_WAIT_START,
        SEQ_WAIT_BASE,
        SEQ_WAIT_CASC,
        SEQ_WAIT_MODE,
        SEQ_READY
    } seq_state_e;

    // command codes for end of interrupt, bits 7:5 of a command word
    localparam logic [2:0] EOI_ANY  = 3'b001;
    localparam logic [2:0] EOI_ONE  = 3'b011;

endpackage

// File: rtl/irq_init_seq.sv
module irq_init_seq
    import prio_irq_pkg::*;
#(
    parameter int BASE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              data_wr,
    input  logic              opt_single,
    input  logic              opt_mode,
    input  logic [BASE_W-1:0] base_in,
    output logic              ready,
    output logic              mask_wr,
    output logic [BASE_W-1:0] base_hi
);

    typedef struct packed {
        seq_state_e        state;
        logic              single;
        logic              mode;
        logic [BASE_W-1:0] base;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d   = seq_q;
        mask_wr = 1'b0;
        if (start_wr) begin
            seq_d.state  = SEQ_WAIT_BASE;
            seq_d.single = opt_single;
            seq_d.mode   = opt_mode;
        end else if (data_wr) begin
            case (seq_q.state)
                SEQ_WAIT_BASE: begin
                    seq_d.base = base_in;
                    if (!seq_q.single)  seq_d.state = SEQ_WAIT_CASC;
                    else if (seq_q.mode) seq_d.state = SEQ_WAIT_MODE;
                    else                 seq_d.state = SEQ_READY;
                end
                SEQ_WAIT_CASC: seq_d.state = seq_q.mode ? SEQ_WAIT_MODE : SEQ_READY;
                SEQ_WAIT_MODE: seq_d.state = SEQ_READY;
                SEQ_READY:     mask_wr = 1'b1;
                default:       ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state  <= SEQ_WAIT_START;
            seq_q.single <= 1'b0;
            seq_q.mode   <= 1'b0;
            seq_q.base   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready   = (seq_q.state == SEQ_READY);
    assign base_hi = seq_q.base;

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  insvc,
    output logic          raise,
    output logic [IW-1:0] win_idx
);

    logic          req_hit, svc_hit;
    logic [IW-1:0] svc_idx;

    // scan from the lowest priority upward so the lowest index is kept last
    always_comb begin
        req_hit = 1'b0;
        svc_hit = 1'b0;
        win_idx = '0;
        svc_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                req_hit = 1'b1;
                win_idx = IW'(i);
            end
            if (insvc[i]) begin
                svc_hit = 1'b1;
                svc_idx = IW'(i);
            end
        end
        raise = req_hit && (!svc_hit || (win_idx < svc_idx));
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] irq_in,
    input  logic              inta,
    output logic              int_out,
    output logic [DATA_W-1:0] vector
);

    localparam int N_IRQ  = DATA_W;
    localparam int IDX_W  = $clog2(N_IRQ);
    localparam int BASE_W = DATA_W - IDX_W;

    typedef struct packed {
        logic [N_IRQ-1:0]  prev;
        logic [N_IRQ-1:0]  irr;
        logic [N_IRQ-1:0]  isr;
        logic [N_IRQ-1:0]  imr;
        logic [DATA_W-1:0] vec;
        logic [DATA_W-1:0] rdat;
    } ctl_t;

    ctl_t st_d, st_q;

    logic              cmd_wr, data_wr, start_wr, ready, mask_wr, raise;
    logic              eoi_any, eoi_one;
    logic [BASE_W-1:0] base_hi;
    logic [IDX_W-1:0]  win_idx;

    assign cmd_wr   = cs && wr && !addr;
    assign data_wr  = cs && wr && addr;
    assign start_wr = cmd_wr && wdata[4];
    assign eoi_any  = ready && cmd_wr && !wdata[4] && !wdata[3]
                      && (wdata[DATA_W-1:DATA_W-3] == EOI_ANY);
    assign eoi_one  = ready && cmd_wr && !wdata[4] && !wdata[3]
                      && (wdata[DATA_W-1:DATA_W-3] == EOI_ONE);

    irq_init_seq #(.BASE_W(BASE_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_wr   (start_wr),
        .data_wr    (data_wr),
        .opt_single (wdata[1]),
        .opt_mode   (wdata[0]),
        .base_in    (wdata[DATA_W-1:IDX_W]),
        .ready      (ready),
        .mask_wr    (mask_wr),
        .base_hi    (base_hi)
    );

    irq_prio_resolver #(.N(N_IRQ), .IW(IDX_W)) i_res (
        .pend    (st_q.irr & ~st_q.imr),
        .insvc   (st_q.isr),
        .raise   (raise),
        .win_idx (win_idx)
    );

    always_comb begin
        logic [N_IRQ-1:0] irr_clr, isr_set, isr_clr;
        logic [N_IRQ-1:0] svc_low;
        st_d    = st_q;
        irr_clr = '0;
        isr_set = '0;
        isr_clr = '0;
        st_d.prev = irq_in;

        if (inta) begin
            if (raise) begin
                irr_clr[win_idx] = 1'b1;
                isr_set[win_idx] = 1'b1;
                st_d.vec = {base_hi, win_idx};
            end else begin
                st_d.vec = {base_hi, {IDX_W{1'b1}}};
            end
        end

        // lowest set bit of the in-service register
        svc_low = st_q.isr & (~st_q.isr + 1'b1);
        if (eoi_any) isr_clr = svc_low;
        if (eoi_one) isr_clr[wdata[IDX_W-1:0]] = 1'b1;

        st_d.irr = (st_q.irr & ~irr_clr) | (irq_in & ~st_q.prev);
        st_d.isr = (st_q.isr & ~isr_clr) | isr_set;
        if (mask_wr) st_d.imr = wdata;

        if (start_wr) begin
            st_d.irr = '0;
            st_d.isr = '0;
            st_d.imr = '1;
        end

        if (cs && rd) st_d.rdat = addr ? st_q.imr : st_q.isr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prev <= '0;
            st_q.irr  <= '0;
            st_q.isr  <= '0;
            st_q.imr  <= '1;
            st_q.vec  <= '0;
            st_q.rdat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_out = raise;
    assign vector  = st_q.vec;
    assign rdata   = st_q.rdat;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int DW = 8,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs,
    input logic          addr,
    input logic          wr,
    input logic [DW-1:0] wdata,
    input logic          inta,
    input logic          int_out,
    input logic [DW-1:0] vector,
    input logic          ready,
    input logic [DW-1:0] imr,
    input logic [DW-1:0] isr
);

    // R5
    mask_all_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imr == '1) |-> !int_out);

    // R7
    ack_enters_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && int_out && !(cs && wr)) |=>
        ($countones(isr) == $countones($past(isr)) + 1));

    // R9
    eoi_any_one_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cs && wr && !addr && wdata == 8'h20 && isr != '0 && !inta) |=>
        ($countones(isr) + 1 == $countones($past(isr))));

    // R10
    eoi_one_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cs && wr && !addr && wdata[DW-1:IW] == 5'b01100 && !inta) |=>
        !isr[$past(wdata[IW-1:0])]);

    // R11
    spurious_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !int_out && !(cs && wr)) |=>
        ((vector[IW-1:0] == {IW{1'b1}}) && $stable(isr)));

    // R12
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !addr && wdata[4]) |=>
        ((isr == '0) && (imr == '1) && !int_out));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.DW(DATA_W), .IW(IDX_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .addr    (addr),
    .wr      (wr),
    .wdata   (wdata),
    .inta    (inta),
    .int_out (int_out),
    .vector  (vector),
    .ready   (ready),
    .imr     (st_q.imr),
    .isr     (st_q.isr)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, addr = 1'b0, wr = 1'b0, rd = 1'b0, inta = 1'b0;
    logic [7:0] wdata = '0, irq_in = '0;
    logic [7:0] rdata, vector;
    logic       int_out;

    int tests = 0, fails = 0;
    logic [7:0] exp_vec_q[$];

    always #5 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .wr(wr), .rd(rd),
        .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .inta(inta),
        .int_out(int_out), .vector(vector)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr_port(input logic a, input logic [7:0] v);
        @(negedge clk); cs = 1'b1; wr = 1'b1; addr = a; wdata = v;
        @(negedge clk); cs = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_port(input logic a, output logic [7:0] v);
        @(negedge clk); cs = 1'b1; rd = 1'b1; addr = a;
        @(negedge clk); cs = 1'b0; rd = 1'b0; v = rdata;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk); irq_in = v;
        @(negedge clk);
    endtask

    // driver: pulse acknowledge and push the expected vector
    task automatic ack(input logic [7:0] exp_vec);
        @(negedge clk); inta = 1'b1; exp_vec_q.push_back(exp_vec);
        @(negedge clk); inta = 0;
    endtask

    // monitor: compare each vector produced after an acknowledge
    initial begin
        forever begin
            @(posedge clk);
            if (inta) begin
                @(negedge clk);
                if (exp_vec_q.size() == 0) check("R6 vector queue empty", vector, 8'hxx);
                else check("R6/R11 vector", vector, exp_vec_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 int_out", {7'd0, int_out}, 8'h00);
        rd_port(1'b1, r); check("R1 mask", r, 8'hFF);
        rd_port(1'b0, r); check("R1 isr", r, 8'h00);

        // R2 data write before init ignored
        wr_port(1'b1, 8'h00);
        rd_port(1'b1, r); check("R2 mask", r, 8'hFF);
        set_irq(8'h01); check("R2 int_out", {7'd0, int_out}, 8'h00);
        set_irq(8'h00);

        // R3 single, no mode word
        wr_port(1'b0, 8'h1A);
        wr_port(1'b1, 8'h20);
        wr_port(1'b1, 8'h5A);
        rd_port(1'b1, r); check("R3 mask", r, 8'h5A);

        // R4 cascaded with mode word, R12 mask set on restart
        wr_port(1'b0, 8'h11);
        rd_port(1'b1, r); check("R12 mask", r, 8'hFF);
        wr_port(1'b1, 8'h40);
        wr_port(1'b1, 8'h04);
        rd_port(1'b1, r); check("R4 after casc", r, 8'hFF);
        wr_port(1'b1, 8'h0D);
        rd_port(1'b1, r); check("R4 after mode", r, 8'hFF);
        wr_port(1'b1, 8'hF7);
        rd_port(1'b1, r); check("R4 mask", r, 8'hF7);

        // R5 masking
        set_irq(8'h20); check("R5 masked", {7'd0, int_out}, 8'h00);
        set_irq(8'h28); check("R5 unmasked", {7'd0, int_out}, 8'h01);

        // R6 R7 acknowledge
        ack(8'h43);
        check("R7 int_out", {7'd0, int_out}, 8'h00);
        rd_port(1'b0, r); check("R7 isr", r, 8'h08);

        // R8 nesting
        wr_port(1'b1, 8'h00);
        check("R8 lower blocked", {7'd0, int_out}, 8'h00);
        set_irq(8'h2A); check("R8 higher passes", {7'd0, int_out}, 8'h01);
        ack(8'h41);
        rd_port(1'b0, r); check("R7 isr nest", r, 8'h0A);

        // R9 non-specific
        wr_port(1'b0, 8'h20);
        rd_port(1'b0, r); check("R9 isr", r, 8'h08);
        check("R9 int_out", {7'd0, int_out}, 8'h00);

        // R10 specific
        wr_port(1'b0, 8'h63);
        rd_port(1'b0, r); check("R10 isr", r, 8'h00);
        check("R10 int_out", {7'd0, int_out}, 8'h01);
        ack(8'h45);
        wr_port(1'b0, 8'h65);

        // R6 simultaneous, R11 spurious
        set_irq(8'h00);
        set_irq(8'h44); check("R6 int_out", {7'd0, int_out}, 8'h01);
        ack(8'h42);
        check("R8 blocked by svc", {7'd0, int_out}, 8'h00);
        ack(8'h47);
        rd_port(1'b0, r); check("R11 isr", r, 8'h04);
        wr_port(1'b0, 8'h20);
        check("R11 req kept", {7'd0, int_out}, 8'h01);
        ack(8'h46);

        // R10 only named bit
        set_irq(8'h45);
        check("R8 preempt", {7'd0, int_out}, 8'h01);
        ack(8'h40);
        wr_port(1'b0, 8'h66);
        rd_port(1'b0, r); check("R10 only bit6", r, 8'h01);
        wr_port(1'b0, 8'h20);

        // R5 request held after input falls
        set_irq(8'h00);
        wr_port(1'b1, 8'h02);
        set_irq(8'h02); check("R5 masked held", {7'd0, int_out}, 8'h00);
        set_irq(8'h00);
        wr_port(1'b1, 8'h00);
        check("R5 held request", {7'd0, int_out}, 8'h01);

        // R12 restart clears pending
        wr_port(1'b0, 8'h12);
        check("R12 int_out", {7'd0, int_out}, 8'h00);
        rd_port(1'b0, r); check("R12 isr", r, 8'h00);
        wr_port(1'b1, 8'h30);
        wr_port(1'b1, 8'h00);
        check("R12 irr cleared", {7'd0, int_out}, 8'h00);

        // R5 held level gives one request only
        set_irq(8'h10); check("R5 edge", {7'd0, int_out}, 8'h01);
        ack(8'h34);
        wr_port(1'b0, 8'h20);
        check("R5 no re-request", {7'd0, int_out}, 8'h00);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule